// File: doc/BRIEF.md
# Two-Rate Two-Channel FSK Modulator

This block is the digital carrier generator of a half-duplex power-line transmitter. It runs from the 11.0592 MHz reference clock, which is the only clock in the block. From that clock it divides down a transmit bit clock of 600 or 1200 baud. On every rising edge of the bit clock it captures one data bit and steers a phase accumulator to one of two tones. The pair of tones comes from a fixed four-entry table picked by a rate bit and a channel bit.

The tone spacing is 600 Hz at the low rate and 1200 Hz at the high rate. The full accumulator phase is brought out so that later logic can address a sine table with its upper bits. The accumulator's top bit is also driven out as a square-wave carrier. Changing from one tone to the other only changes the per-cycle increment, so the carrier phase never jumps at a bit boundary. Dropping the enable parks the whole block in a quiet, zeroed state.

Top module: `fskm_modulator`

## Requirements
- R1: While `rst_n` is low, `phase` is 0 and `bit_clk` and `carrier` are 0.
- R2: With `en` high, `bit_clk` has a period of 18432 reference cycles when `rate_sel`=0 (600 baud) and 9216 cycles when `rate_sel`=1 (1200 baud). It is high for exactly half of each period.
- R3: `tx_data` is captured on the reference edge where `bit_clk` rises. The increment changes from the next reference edge onward. Values of `tx_data` at other times have no effect.
- R4: The tones in Hz, given as (mark for data 1, space for data 0) and indexed by {`rate_sel`,`chan_sel`}, are: 00 → (81750, 82350); 01 → (67200, 67800); 10 → (71400, 72600); 11 → (85950, 87150).
- R5: On each enabled reference edge, `phase` advances modulo 2^32 by the tuning word round(f × 2^32 / 11059200) of the tone currently selected.
- R6: The accumulator is never cleared at a bit boundary. Across a tone change the phase step is exactly the tuning word, with no jump.
- R7: `carrier` always equals bit 31 of `phase`.
- R8: In the reference cycle after `en` is sampled low, `phase` is 0 and `bit_clk` and `carrier` are 0. The captured data bit is cleared to 0.
- R9: After `en` rises, the space tone (data 0) is used until the first rising edge of `bit_clk`. That edge comes half a bit period after enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 11.0592 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Transmit enable; low holds the block at zero |
| rate_sel | input | 1 | 0 = 600 baud, 1 = 1200 baud |
| chan_sel | input | 1 | Channel choice within the rate |
| tx_data | input | 1 | Transmit bit, captured at bit clock rise |
| bit_clk | output | 1 | Transmit bit clock, 50% duty |
| phase | output | 32 | Phase accumulator value |
| carrier | output | 1 | Square-wave carrier (phase MSB) |

## Verification
The in-RTL properties check the following on every cycle:
- the divider count stays inside its range;
- each capture strobe is followed by a rising bit clock;
- a falling bit clock coincides with a wrapped divider;
- a disabled block is quiet one cycle later.

Only the bench scenarios can show the rest:
- the exact tone table and tuning words;
- the measured period and duty at both rates;
- that the space tone is used before the first capture;
- that the phase step stays equal to the selected tuning word across every bit change.

// File: rtl/fskm_pkg.sv
package fskm_pkg;

   // Tone table, index = {rate, channel, data}; data 1 is the lower (mark) tone
   localparam int unsigned TONE_HZ [8] = '{
      32'd82350, 32'd81750,   // rate 0, channel 0
      32'd67800, 32'd67200,   // rate 0, channel 1
      32'd72600, 32'd71400,   // rate 1, channel 0
      32'd87150, 32'd85950    // rate 1, channel 1
   };

   // Rounded phase increment for a tone of f_hz at a reference of ref_hz
   function automatic logic [63:0] tune_word(input logic [63:0] f_hz,
                                             input logic [63:0] ref_hz,
                                             input int unsigned  w);
      return ((f_hz << w) + (ref_hz >> 1)) / ref_hz;
   endfunction

endpackage

// File: rtl/fskm_bitclk.sv
module fskm_bitclk #(
   parameter int unsigned REF_HZ  = 11059200,
   parameter int unsigned BAUD_LO = 600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic rate_sel,
   output logic bit_clk,
   output logic sample_stb
);
   localparam int unsigned DIV_LO = REF_HZ / BAUD_LO;
   localparam int unsigned DIV_HI = DIV_LO / 2;
   localparam int unsigned CNT_W  = $clog2(DIV_LO);

   logic [CNT_W-1:0] cnt_q, cnt_nxt, last_c, half_c;

   always_comb begin
      last_c     = rate_sel ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
      half_c     = rate_sel ? CNT_W'(DIV_HI / 2) : CNT_W'(DIV_LO / 2);
      cnt_nxt    = (cnt_q >= last_c) ? '0 : cnt_q + 1'b1;
      sample_stb = en && (cnt_nxt == half_c);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         bit_clk <= 1'b0;
      end else if (!en) begin
         cnt_q   <= '0;
         bit_clk <= 1'b0;
      end else begin
         cnt_q   <= cnt_nxt;
         bit_clk <= (cnt_nxt >= half_c);
      end
   end

   // R2: divider never leaves the low-rate range
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(DIV_LO));

   // R2: bit clock falls only when the count wraps (or enable clears it)
   p_fall_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bit_clk) |-> (cnt_q == '0));

   // R3: the capture strobe coincides with the bit clock rising
   p_rise_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> $rose(bit_clk));

endmodule

// File: rtl/fskm_tune.sv
module fskm_tune #(
   parameter int unsigned REF_HZ  = 11059200,
   parameter int unsigned PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               sample_stb,
   input  logic               tx_data,
   input  logic               rate_sel,
   input  logic               chan_sel,
   output logic [PHASE_W-1:0] tw
);
   localparam int unsigned N_TONES = 8;

   logic [PHASE_W-1:0] tw_tab [N_TONES];
   logic               data_q;

   for (genvar i = 0; i < N_TONES; i++) begin : g_tw
      localparam logic [63:0] TW_FULL =
         fskm_pkg::tune_word(64'(fskm_pkg::TONE_HZ[i]), 64'(REF_HZ), PHASE_W);
      assign tw_tab[i] = TW_FULL[PHASE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          data_q <= 1'b0;
      else if (!en)        data_q <= 1'b0;
      else if (sample_stb) data_q <= tx_data;
   end

   assign tw = tw_tab[{rate_sel, chan_sel, data_q}];

endmodule

// File: rtl/fskm_phase_acc.sv
module fskm_phase_acc #(
   parameter int unsigned PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [PHASE_W-1:0] tw,
   output logic [PHASE_W-1:0] phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   phase <= '0;
      else if (!en) phase <= '0;
      else          phase <= phase + tw;
   end
endmodule

// File: rtl/fskm_modulator.sv
module fskm_modulator #(
   parameter int unsigned REF_HZ  = 11059200,
   parameter int unsigned BAUD_LO = 600,
   parameter int unsigned PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               rate_sel,
   input  logic               chan_sel,
   input  logic               tx_data,
   output logic               bit_clk,
   output logic [PHASE_W-1:0] phase,
   output logic               carrier
);
   initial begin
      assert (REF_HZ % BAUD_LO == 0)
         else $error("reference must be a whole multiple of the low baud rate");
      assert ((REF_HZ / BAUD_LO) % 4 == 0)
         else $error("low-rate divisor must split evenly for both rates");
      assert (PHASE_W >= 8 && PHASE_W <= 48)
         else $error("phase width out of supported range");
   end

   logic               sample_stb;
   logic [PHASE_W-1:0] tw;

   fskm_bitclk #(.REF_HZ(REF_HZ), .BAUD_LO(BAUD_LO)) u_bitclk (
      .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel),
      .bit_clk(bit_clk), .sample_stb(sample_stb));

   fskm_tune #(.REF_HZ(REF_HZ), .PHASE_W(PHASE_W)) u_tune (
      .clk(clk), .rst_n(rst_n), .en(en), .sample_stb(sample_stb),
      .tx_data(tx_data), .rate_sel(rate_sel), .chan_sel(chan_sel), .tw(tw));

   fskm_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .en(en), .tw(tw), .phase(phase));

   assign carrier = phase[PHASE_W-1];

   // R8: a disabled block is zeroed and silent on the next cycle
   p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (phase == '0 && !bit_clk && !carrier));

endmodule

// File: tb/test_fskm_modulator.sv
module test_fskm_modulator;
   localparam int CLK_P   = 90;
   localparam int DIV_LO  = 18432;
   localparam int DIV_HI  = 9216;
   localparam int WDOG    = 195000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, rate_sel = 1'b0, chan_sel = 1'b0, tx_data = 1'b0;
   logic        bit_clk, carrier;
   logic [31:0] phase;

   int n_cmp = 0, n_bad = 0;
   bit exp_q[$];

   fskm_modulator i_fskm_modulator (
      .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel),
      .chan_sel(chan_sel), .tx_data(tx_data), .bit_clk(bit_clk),
      .phase(phase), .carrier(carrier));

   always #(CLK_P/2) clk = ~clk;

   function automatic longint unsigned tone_hz(bit r, bit c, bit d);
      case ({r, c, d})
         3'b001: return 81750;  3'b000: return 82350;
         3'b011: return 67200;  3'b010: return 67800;
         3'b101: return 71400;  3'b100: return 72600;
         3'b111: return 85950;  default: return 87150;
      endcase
   endfunction

   function automatic logic [31:0] exp_tw(bit r, bit c, bit d);
      longint unsigned num;
      num = tone_hz(r, c, d) * 64'd4294967296 + 64'd5529600;
      return 32'(num / 64'd11059200);
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // Monitor / scoreboard: pops one expected bit per bit-clock rise
   initial begin
      logic [31:0] prev_phase = '0;
      bit en_p = 0, r_p = 0, c_p = 0, bclk_p = 0, cur = 0, seen = 0;
      int samp = 0, high = 0, div;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            en_p = 0; prev_phase = '0; bclk_p = 0;
         end else begin
            div = r_p ? DIV_HI : DIV_LO;
            if (en_p) begin
               chk((phase - prev_phase) == exp_tw(r_p, c_p, cur),
                   "R4 R5 R6 phase step", longint'(phase - prev_phase),
                   longint'(exp_tw(r_p, c_p, cur)));
               samp++;
               if (bit_clk) high++;
               if (bit_clk && !bclk_p) begin
                  if (seen) chk(samp == div, "R2 bit period", samp, div);
                  else      chk(samp == div/2, "R9 first rise delay", samp, div/2);
                  seen = 1; samp = 0;
                  if (exp_q.size() == 0)
                     chk(0, "R3 capture with empty queue", 0, 1);
                  else
                     cur = exp_q.pop_front();
               end
               if (!bit_clk && bclk_p) begin
                  chk(high == div/2, "R2 high time", high, div/2);
                  high = 0;
               end
            end else begin
               chk(phase == 0 && !bit_clk && !carrier, "R8 disabled quiet",
                   longint'({phase, bit_clk, carrier}), 0);
               cur = 0; samp = 0; high = 0; seen = 0;
            end
            chk(carrier == phase[31], "R7 carrier msb", carrier, phase[31]);
            prev_phase = phase; bclk_p = bit_clk;
            en_p = en; r_p = rate_sel; c_p = chan_sel;
         end
      end
   end

   task automatic wait_fall();
      bit p;
      p = bit_clk;
      forever begin
         @(posedge clk); #(CLK_P/4);
         if (p && !bit_clk) break;
         p = bit_clk;
      end
   endtask

   // Driver: one enabled segment per rate/channel; R3 data changes mid-cell
   task automatic run_seg(bit r, bit c, int n, bit [7:0] pat);
      @(posedge clk); #(CLK_P/4); en = 0;
      repeat (3) begin @(posedge clk); #(CLK_P/4); end
      rate_sel = r; chan_sel = c; tx_data = pat[0];
      exp_q.push_back(pat[0]); en = 1;
      for (int i = 1; i < n; i++) begin
         wait_fall();
         tx_data = pat[i];
         exp_q.push_back(pat[i]);
      end
      wait_fall();
      tx_data = ~tx_data;   // R3: toggles away from a rise are ignored
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(phase == 0 && !bit_clk && !carrier, "R1 reset state",
          longint'({phase, bit_clk, carrier}), 0);
      @(posedge clk); #(CLK_P/4); rst_n = 1;
      run_seg(1'b0, 1'b0, 3, 8'b101);
      run_seg(1'b0, 1'b1, 2, 8'b10);
      run_seg(1'b1, 1'b0, 3, 8'b011);
      run_seg(1'b1, 1'b1, 3, 8'b110);
      @(posedge clk); #(CLK_P/4); en = 0;
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(exp_q.size() == 0, "R3 all bits captured", exp_q.size(), 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule